// File: doc/BRIEF.md
# SD Card SPI-Mode Command Engine

This block issues a single memory-card command over an SPI-mode link and hands back the first response byte the card returns. A controller above it presents a request: a 6-bit command index, a flag that marks an application-specific command, and a 32-bit argument. Below it, the block drives chip select and a byte-exchange port on an SPI master. Each exchange is started with a one-cycle strobe and ends when the master returns a done pulse carrying the received byte.

For each command the engine first deselects the card and clocks one idle byte. It then selects the card, throws away one byte and keeps reading until the card reports ready with 0xFF. Next it shifts out the six-byte command frame and polls for the response. An application command is preceded automatically by CMD55. After a stop-transmission command (CMD12), one stuff byte is skipped before polling starts. If the card stays busy past the ready timeout, which is counted in millisecond ticks, the card is released and 0xFF is reported. A normal completion leaves the card selected so that a data phase can follow.

Top module: `sd_cmd_engine`

## Requirements
- R1: The command frame is six bytes: first 0x40 OR'd with the 6-bit index, then the argument from bits 31:24 down to bits 7:0, then one closing byte.
- R2: The closing byte is 0x95 when the index is 0, 0x87 when the index is 8, and 0x01 for every other index.
- R3: When `req_app` is 1, the engine first runs a full command with index 55 and argument 0. If that response is 0x00 or 0x01, it then runs the requested command and reports that command's response.
- R4: When the index-55 response of an application request is above 0x01, that response is reported and the requested command is never sent.
- R5: Before every frame: one exchange with `cs_n` high, then `cs_n` goes low, one exchange is discarded, and exchanges repeat until a received byte equals 0xFF. `cs_n` is stable while an exchange is outstanding.
- R6: If 0xFF is not received before READY_TIMEOUT_MS (default 500) `ms_tick` pulses have been counted, the engine raises `cs_n`, performs one more exchange, and reports 0xFF without sending any frame byte.
- R7: After the last frame byte of index 12, one received byte is discarded before response polling, even if its bit 7 is clear.
- R8: Polling reads at most POLL_LIMIT (default 10) bytes and reports the first byte whose bit 7 is 0, or else the last byte read.
- R9: Only one exchange is outstanding at a time. `xfer_start` is never raised before the previous exchange's `xfer_done`. Every exchange outside the frame transmits 0xFF.
- R10: `busy` is high from the cycle after a request is accepted until `rsp_valid` pulses. `rsp_valid` lasts one cycle, in the cycle `busy` falls. `req_valid` while busy is ignored.
- R11: `cs_n` is high out of reset and stays low after a normal (non-timeout) completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, accepted while idle |
| req_index | input | 6 | Command index |
| req_app | input | 1 | Send CMD55 prefix first |
| req_arg | input | 32 | Command argument |
| busy | output | 1 | Command in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 8 | Response byte |
| ms_tick | input | 1 | One pulse per millisecond |
| xfer_start | output | 1 | Start one byte exchange |
| xfer_tx | output | 8 | Byte to transmit |
| xfer_done | input | 1 | Exchange finished |
| xfer_rx | input | 8 | Byte received, valid with xfer_done |
| cs_n | output | 1 | Card chip select, active low |

## Verification
Every cycle, the bound checker enforces the exchange handshake (a single outstanding byte, start only while busy) and a stable chip select during each byte. It also enforces the relationship between busy and the response strobe, and the rule that the card is still selected after a normal finish. The bench's scenarios show the frame contents and the closing-byte choice, and the prefix and abort paths of application commands. They also cover the CMD12 stuff byte, the poll limit and the ready timeout, because each of these depends on the byte sequence a card returns.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RELEASE,
        ST_FLUSH,
        ST_READY,
        ST_BAIL,
        ST_FRAME,
        ST_STUFF,
        ST_POLL
    } eng_state_e;

    typedef struct packed {
        logic [5:0]  index;
        logic [31:0] arg;
    } sd_cmd_t;

    localparam logic [7:0] IDLE_BYTE  = 8'hFF;
    localparam logic [5:0] IDX_RESET  = 6'd0;
    localparam logic [5:0] IDX_IFCOND = 6'd8;
    localparam logic [5:0] IDX_STOP   = 6'd12;
    localparam logic [5:0] IDX_APP    = 6'd55;

    function automatic logic [7:0] close_byte(input logic [5:0] idx);
        if (idx == IDX_RESET)       return 8'h95;
        else if (idx == IDX_IFCOND) return 8'h87;
        else                        return 8'h01;
    endfunction

endpackage

// File: rtl/sd_cmd_framer.sv
module sd_cmd_framer
    import sd_cmd_pkg::*;
(
    input  sd_cmd_t    cmd,
    input  logic [2:0] pos,
    output logic [7:0] frame_byte
);
    always_comb begin
        case (pos)
            3'd0:    frame_byte = {2'b01, cmd.index};
            3'd1:    frame_byte = cmd.arg[31:24];
            3'd2:    frame_byte = cmd.arg[23:16];
            3'd3:    frame_byte = cmd.arg[15:8];
            3'd4:    frame_byte = cmd.arg[7:0];
            default: frame_byte = close_byte(cmd.index);
        endcase
    end
endmodule

// File: rtl/sd_ready_timer.sv
module sd_ready_timer #(
    parameter int unsigned LIMIT = 500
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    input  logic tick,
    output logic expired
);
    localparam int unsigned CW = $clog2(LIMIT + 1);

    logic [CW-1:0] count;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (run && tick && !expired) begin
            count <= count + 1'b1;
        end
    end

    assign expired = (count >= CW'(LIMIT));
endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
    import sd_cmd_pkg::*;
#(
    parameter int unsigned READY_TIMEOUT_MS = 500,
    parameter int unsigned POLL_LIMIT       = 10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [5:0]  req_index,
    input  logic        req_app,
    input  logic [31:0] req_arg,
    output logic        busy,
    output logic        rsp_valid,
    output logic [7:0]  rsp_data,
    input  logic        ms_tick,
    output logic        xfer_start,
    output logic [7:0]  xfer_tx,
    input  logic        xfer_done,
    input  logic [7:0]  xfer_rx,
    output logic        cs_n
);
    localparam int unsigned PW = $clog2(POLL_LIMIT + 1);
    localparam logic [2:0] LAST_POS = 3'd5;

    eng_state_e     state;
    sd_cmd_t        cur_cmd;
    sd_cmd_t        main_cmd;
    logic           prefix_phase;
    logic           pending;
    logic [2:0]     pos;
    logic [PW-1:0]  poll_cnt;
    logic [7:0]     frame_byte;
    logic           expired;
    logic           timer_clear;
    logic           timer_run;

    sd_cmd_framer u_framer (
        .cmd        (cur_cmd),
        .pos        (pos),
        .frame_byte (frame_byte)
    );

    assign timer_clear = (state == ST_RELEASE);
    assign timer_run   = (state == ST_FLUSH) || (state == ST_READY);

    sd_ready_timer #(.LIMIT(READY_TIMEOUT_MS)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clear   (timer_clear),
        .run     (timer_run),
        .tick    (ms_tick),
        .expired (expired)
    );

    assign busy       = (state != ST_IDLE);
    assign xfer_start = busy && !pending;
    assign xfer_tx    = (state == ST_FRAME) ? frame_byte : IDLE_BYTE;

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            cur_cmd      <= '0;
            main_cmd     <= '0;
            prefix_phase <= 1'b0;
            pending      <= 1'b0;
            pos          <= '0;
            poll_cnt     <= '0;
            rsp_valid    <= 1'b0;
            rsp_data     <= 8'h00;
            cs_n         <= 1'b1;
        end else begin
            rsp_valid <= 1'b0;
            if (state == ST_IDLE) begin
                pending <= 1'b0;
                if (req_valid) begin
                    main_cmd      <= '{index: req_index, arg: req_arg};
                    cur_cmd       <= req_app ? '{index: IDX_APP, arg: 32'h0}
                                             : '{index: req_index, arg: req_arg};
                    prefix_phase  <= req_app;
                    cs_n          <= 1'b1;
                    state         <= ST_RELEASE;
                end
            end else if (!pending) begin
                pending <= 1'b1;
            end else if (xfer_done) begin
                pending <= 1'b0;
                case (state)
                    ST_RELEASE: begin
                        cs_n  <= 1'b0;
                        state <= ST_FLUSH;
                    end
                    ST_FLUSH: state <= ST_READY;
                    ST_READY: begin
                        if (xfer_rx == IDLE_BYTE) begin
                            pos   <= '0;
                            state <= ST_FRAME;
                        end else if (expired) begin
                            cs_n  <= 1'b1;
                            state <= ST_BAIL;
                        end
                    end
                    ST_BAIL: begin
                        rsp_valid <= 1'b1;
                        rsp_data  <= IDLE_BYTE;
                        state     <= ST_IDLE;
                    end
                    ST_FRAME: begin
                        if (pos == LAST_POS) begin
                            poll_cnt <= '0;
                            state    <= (cur_cmd.index == IDX_STOP) ? ST_STUFF : ST_POLL;
                        end else begin
                            pos <= pos + 3'd1;
                        end
                    end
                    ST_STUFF: state <= ST_POLL;
                    ST_POLL: begin
                        if (!xfer_rx[7] || poll_cnt == PW'(POLL_LIMIT - 1)) begin
                            if (prefix_phase && xfer_rx <= 8'h01) begin
                                prefix_phase <= 1'b0;
                                cur_cmd      <= main_cmd;
                                cs_n         <= 1'b1;
                                state        <= ST_RELEASE;
                            end else begin
                                rsp_valid <= 1'b1;
                                rsp_data  <= xfer_rx;
                                state     <= ST_IDLE;
                            end
                        end else begin
                            poll_cnt <= poll_cnt + 1'b1;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/sd_cmd_checker.sv
module sd_cmd_checker (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       rsp_valid,
    input logic [7:0] rsp_data,
    input logic       xfer_start,
    input logic       xfer_done,
    input logic       cs_n
);
    logic outstanding;

    always_ff @(posedge clk) begin
        if (rst)             outstanding <= 1'b0;
        else if (xfer_start) outstanding <= 1'b1;
        else if (xfer_done)  outstanding <= 1'b0;
    end

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        xfer_start |-> !outstanding); // R9

    AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        xfer_start |-> busy); // R10

    AST_RSP_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (!busy && $past(busy))); // R10

    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R10

    AST_CS_HELD_IN_XFER: assert property (@(posedge clk) disable iff (rst)
        outstanding |-> $stable(cs_n)); // R5

    AST_SELECTED_AFTER_OK: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_data != 8'hFF) |-> !cs_n); // R11
endmodule

bind sd_cmd_engine sd_cmd_checker u_sd_cmd_checker (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data),
    .xfer_start (xfer_start),
    .xfer_done  (xfer_done),
    .cs_n       (cs_n)
);

// File: tb/test_sd_cmd_engine.sv
module test_sd_cmd_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [5:0]  req_index = '0;
    logic        req_app = 1'b0;
    logic [31:0] req_arg = '0;
    logic        busy, rsp_valid, xfer_start, cs_n;
    logic [7:0]  rsp_data, xfer_tx;
    logic        ms_tick = 1'b0;
    logic        xfer_done = 1'b0;
    logic [7:0]  xfer_rx = 8'h00;

    int n_tests = 0;
    int n_fail  = 0;

    // card model state
    logic [7:0] script [0:31];
    int         script_len = 0;
    logic [7:0] dflt = 8'hFF;
    logic       log_clr = 1'b0;
    int         n_x = 0;
    logic [7:0] log_tx [0:63];
    logic       log_cs [0:63];
    logic [7:0] last_tx;
    logic       last_cs;
    logic [7:0] rx_next;
    int         dly = 0;
    logic [7:0] got;

    always #10 clk = ~clk;

    sd_cmd_engine i_sd_cmd_engine (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_index(req_index),
        .req_app(req_app), .req_arg(req_arg), .busy(busy), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .ms_tick(ms_tick), .xfer_start(xfer_start),
        .xfer_tx(xfer_tx), .xfer_done(xfer_done), .xfer_rx(xfer_rx), .cs_n(cs_n)
    );

    // millisecond tick: one pulse every 8 clocks
    always @(posedge clk) begin
        int c;
        c = ($time / 20) % 8;
        ms_tick <= (c == 0);
    end

    // byte-exchange model with two cycles of latency
    always @(posedge clk) begin
        xfer_done <= 1'b0;
        if (log_clr) begin
            n_x <= 0;
            dly <= 0;
        end else if (xfer_start) begin
            if (n_x < 64) begin
                log_tx[n_x] <= xfer_tx;
                log_cs[n_x] <= cs_n;
            end
            last_tx <= xfer_tx;
            last_cs <= cs_n;
            rx_next <= (n_x < script_len) ? script[n_x] : dflt;
            n_x     <= n_x + 1;
            dly     <= 2;
        end else if (dly != 0) begin
            dly <= dly - 1;
            if (dly == 1) begin
                xfer_done <= 1'b1;
                xfer_rx   <= rx_next;
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic load(input logic [7:0] b [], input logic [7:0] d);
        foreach (b[i]) script[i] = b[i];
        script_len = b.size();
        dflt = d;
        @(negedge clk);
        log_clr = 1'b1;
        @(negedge clk);
        log_clr = 1'b0;
    endtask

    task automatic issue(input logic [5:0] idx, input logic app, input logic [31:0] arg,
                         input bit poke_busy);
        int waited;
        @(negedge clk);
        req_valid = 1'b1; req_index = idx; req_app = app; req_arg = arg;
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 busy after accept", busy, 1);
        waited = 0;
        while (!rsp_valid && waited < 20000) begin
            if (poke_busy && waited == 5) begin
                req_valid = 1'b1; req_index = 6'd17;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
            waited++;
        end
        req_valid = 1'b0;
        check("R10 response arrived", rsp_valid, 1);
        check("R10 busy low with rsp_valid", busy, 0);
        got = rsp_data;
    endtask

    task automatic check_frame(input int at, input logic [7:0] f [6], input string tag);
        for (int i = 0; i < 6; i++) check(tag, log_tx[at + i], f[i]);
    endtask

    task automatic t_reset;
        check("R11 cs_n after reset", cs_n, 1);
        check("R10 busy after reset", busy, 0);
        check("R9 no start after reset", xfer_start, 0);
    endtask

    task automatic t_cmd0;
        load('{8'hFF,8'hFF,8'hFF,8'hFF,8'hFF,8'hFF,8'hFF,8'hFF,8'hFF,8'hFF,8'h01}, 8'hFF);
        issue(6'd0, 1'b0, 32'h0, 1'b1);
        check("R8 CMD0 response", got, 8'h01);
        check("R5 release byte cs high", log_cs[0], 1);
        check("R5 flush byte cs low", log_cs[1], 0);
        check("R9 idle byte value", log_tx[1], 8'hFF);
        check_frame(3, '{8'h40,8'h00,8'h00,8'h00,8'h00,8'h95}, "R2 CMD0 frame");
        check("R9 poll byte value", log_tx[9], 8'hFF);
        check("R11 cs_n low after finish", cs_n, 0);
        repeat (40) @(negedge clk);
        check("R10 request while busy ignored", n_x, 11);
        check("R10 still idle", busy, 0);
    endtask

    task automatic t_cmd8_busy;
        load('{8'hFF,8'hFF,8'h00,8'h00,8'hFF,8'hFF,8'hFF,8'hFF,8'hFF,8'hFF,8'hFF,8'h01}, 8'hFF);
        issue(6'd8, 1'b0, 32'h0000_01AA, 1'b0);
        check("R8 CMD8 response", got, 8'h01);
        check("R5 ready waits for FF", n_x, 12);
        check_frame(5, '{8'h48,8'h00,8'h00,8'h01,8'hAA,8'h87}, "R1 R2 CMD8 frame");
    endtask

    task automatic t_app_ok;
        load('{8'hFF,8'hFF,8'hFF,8'hFF,8'hFF,8'hFF,8'hFF,8'hFF,8'hFF,8'h01,
               8'hFF,8'hFF,8'hFF,8'hFF,8'hFF,8'hFF,8'hFF,8'hFF,8'hFF,8'h00}, 8'hFF);
        issue(6'd41, 1'b1, 32'h4000_0000, 1'b0);
        check("R3 main response", got, 8'h00);
        check("R3 total exchanges", n_x, 20);
        check_frame(3, '{8'h77,8'h00,8'h00,8'h00,8'h00,8'h01}, "R3 prefix frame");
        check("R3 deselect between", log_cs[10], 1);
        check_frame(13, '{8'h69,8'h40,8'h00,8'h00,8'h00,8'h01}, "R1 main frame");
    endtask

    task automatic t_app_abort;
        load('{8'hFF,8'hFF,8'hFF,8'hFF,8'hFF,8'hFF,8'hFF,8'hFF,8'hFF,8'h05}, 8'hFF);
        issue(6'd13, 1'b1, 32'h0, 1'b0);
        check("R4 prefix response returned", got, 8'h05);
        repeat (40) @(negedge clk);
        check("R4 main command not sent", n_x, 10);
    endtask

    task automatic t_stop;
        load('{8'hFF,8'hFF,8'hFF,8'hFF,8'hFF,8'hFF,8'hFF,8'hFF,8'hFF,8'h3C,8'h00}, 8'hFF);
        issue(6'd12, 1'b0, 32'h0, 1'b0);
        check("R7 stuff byte skipped", got, 8'h00);
        check("R7 exchange count", n_x, 11);
        check_frame(3, '{8'h4C,8'h00,8'h00,8'h00,8'h00,8'h01}, "R2 CMD12 frame");
    endtask

    task automatic t_poll_limit;
        load('{8'hFF}, 8'hFF);
        issue(6'd17, 1'b0, 32'h0000_1234, 1'b0);
        check("R8 last poll byte", got, 8'hFF);
        check("R8 poll count limit", n_x, 19);
        check("R11 selected after limit", cs_n, 0);
        check("R1 argument low byte", log_tx[7], 8'h34);
    endtask

    task automatic t_timeout;
        longint t0;
        bit all_idle;
        load('{8'h00}, 8'h00);
        t0 = $time;
        issue(6'd17, 1'b0, 32'h0, 1'b0);
        check("R6 timeout response", got, 8'hFF);
        check("R6 waited at least limit", ($time - t0) >= 500 * 8 * 20, 1);
        check("R6 card released", cs_n, 1);
        check("R6 final byte with cs high", last_cs, 1);
        check("R6 final byte value", last_tx, 8'hFF);
        all_idle = 1;
        for (int i = 0; i < 64; i++) if (log_tx[i] != 8'hFF) all_idle = 0;
        check("R6 no frame byte sent", all_idle, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_cmd0();
        t_cmd8_busy();
        t_app_ok();
        t_app_abort();
        t_stop();
        t_poll_limit();
        t_timeout();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #3000000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule